// File: doc/BRIEF.md
# Real-Time Clock Control, Alarm Flags and Pin Steering

This block holds the control byte and the two alarm flags of a real-time clock. It sets the flags from match pulses sent by the timekeeping comparators. Two mode bits then steer the enabled alarm interrupts and a selectable square wave onto two dual-purpose pins. A small register port reads and writes the control byte and the status byte.

A strobe input marks each edge of the 32.768kHz oscillator, so the strobe fires 65536 times per second. This strobe advances a free-running divider. The divider supplies the four square-wave rates: 32.768kHz, 8.192kHz, 4.096kHz and 1Hz. Stopping the oscillator through the control byte clears the divider and holds it at zero.

The interrupt levels are active-low. A flag stays asserted until software writes 0 to it. Pin A can also be released, with its output enable low, so that a board-level clock can use it as an input.

Top module: `rtc_ctrl_steer`

## Requirements
- R1: After reset the control byte (regSel=0) reads 0x18. The status byte (regSel=1) reads 0x00. pinA=1, pinAOe=1 and pinB=0.
- R2: The control byte is laid out as follows: bit7 oscOff, bit6 reads 0 always, bit5 filterEn, bits4:3 rateSel, bit2 intSteer, bit1 alarm2 enable, bit0 alarm1 enable. A write followed by a read returns the written value with bit6 forced to 0.
- R3: The status byte is laid out as follows: bit2 extClk, bit1 alarm2 flag, bit0 alarm1 flag, other bits read 0. A one-cycle match pulse sets its flag on the next clock edge, whatever the state of the enable bit.
- R4: Writing 0 to a flag bit of the status byte clears that flag. Writing 1 leaves the flag unchanged. A match pulse in the same cycle as a clear leaves the flag set.
- R5: With intSteer=0 and extClk=0, pinA is driven and is low while any enabled flag is set. pinB carries the square wave.
- R6: With intSteer=0 and extClk=1, pinAOe=0 and pinA=1 whatever the flags are. pinB carries the square wave.
- R7: With intSteer=1 and extClk=0, pinA is low while alarm1 is flagged and enabled. pinB is low while alarm2 is flagged and enabled.
- R8: With intSteer=1 and extClk=1, pinAOe=0. pinB is low while either alarm is flagged and enabled.
- R9: A flag whose enable bit is 0 never pulls a pin low.
- R10: Each oscEdge strobe advances the divider by one. rateSel=11 makes pinB rise after 1 strobe. rateSel=10 makes it rise after 4 strobes (8.192kHz). rateSel=01 makes it rise after 8 strobes (4.096kHz). rateSel=00 makes it rise after 32768 strobes (1Hz). In every case pinB is low one strobe earlier.
- R11: While oscOff=1 the divider is cleared and oscEdge strobes are ignored, so the square wave stays low. After oscOff returns to 0, counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register select: 0 control byte, 1 status byte |
| regWe | input | 1 | Write strobe for the selected register |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the selected register (combinational) |
| alarm1Match | input | 1 | One-cycle alarm 1 match pulse |
| alarm2Match | input | 1 | One-cycle alarm 2 match pulse |
| oscEdge | input | 1 | Strobe on each 32.768kHz oscillator edge |
| pinA | output | 1 | Pin A level (active-low interrupt) |
| pinAOe | output | 1 | Pin A output enable (0 = pin used as clock input) |
| pinB | output | 1 | Pin B level (square wave or active-low interrupt) |

## Verification
Register writes, flag sets and flag clears all take effect on the clock edge that samples them. Read data and both pins are combinational from the registers, so every such result is due one edge after the stimulus. Divider results are due on the edge that samples the last strobe of a burst. The driver applies stimulus on the falling edge and queues its expectation 1 ns after the next rising edge. The monitor compares the queued items 2 ns after that same rising edge, when the outputs have settled and no input is moving.

// File: rtl/rtc_ctrl_pkg.sv
package rtc_ctrl_pkg;

  // control byte bit positions
  localparam int unsigned CB_OSC_OFF = 7;
  localparam int unsigned CB_RATE_LO = 3;
  localparam int unsigned CB_STEER   = 2;
  localparam logic [7:0]  CTRL_RESET = 8'h18;
  localparam logic [7:0]  CTRL_MASK  = 8'hBF;

  // status byte bit positions (flags sit at bit index = alarm index)
  localparam int unsigned SB_EXTCLK = 2;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_STAT = 1'b1;

  typedef struct packed {
    logic       oscRun;
    logic [1:0] rateSel;
    logic       intSteer;
    logic       extClk;
    logic       irq1;
    logic       irq2;
  } ctl_strobe_t;

endpackage

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_ctrl_pkg::*;
#(
  parameter int unsigned NUM_ALARMS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regSel,
  input  logic                  regWe,
  input  logic [7:0]            regWdata,
  input  logic [NUM_ALARMS-1:0] matchIn,
  output logic [7:0]            regRdata,
  output ctl_strobe_t           strb,
  output logic [NUM_ALARMS-1:0] flagQ
);

  logic [7:0] ctrlQ;
  logic       extClkQ;
  logic       wrCtrl;
  logic       wrStat;

  assign wrCtrl = regWe && (regSel == SEL_CTRL);
  assign wrStat = regWe && (regSel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= CTRL_RESET;
      extClkQ <= 1'b0;
    end else begin
      if (wrCtrl) ctrlQ <= regWdata & CTRL_MASK;
      if (wrStat) extClkQ <= regWdata[SB_EXTCLK];
    end
  end

  // one flag per alarm: a match sets, a written 0 clears, set wins
  genvar gi;
  for (gi = 0; gi < NUM_ALARMS; gi++) begin : g_flag
    logic clrReq;
    assign clrReq = wrStat && !regWdata[gi];
    always_ff @(posedge clk) begin
      if (!rstN) flagQ[gi] <= 1'b0;
      else       flagQ[gi] <= matchIn[gi] | (flagQ[gi] & ~clrReq);
    end
  end

  always_comb begin
    regRdata = 8'h00;
    if (regSel == SEL_CTRL) begin
      regRdata = ctrlQ;
    end else begin
      regRdata[SB_EXTCLK]     = extClkQ;
      regRdata[NUM_ALARMS-1:0] = flagQ;
    end
  end

  assign strb.oscRun   = !ctrlQ[CB_OSC_OFF];
  assign strb.rateSel  = ctrlQ[CB_RATE_LO+1:CB_RATE_LO];
  assign strb.intSteer = ctrlQ[CB_STEER];
  assign strb.extClk   = extClkQ;
  assign strb.irq1     = flagQ[0] & ctrlQ[0];
  assign strb.irq2     = flagQ[1] & ctrlQ[1];

endmodule

// File: rtl/rtc_ctrl_dp.sv
module rtc_ctrl_dp
  import rtc_ctrl_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned TAP_8K = 2,
  parameter int unsigned TAP_4K = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        oscEdge,
  input  ctl_strobe_t strb,
  output logic        pinA,
  output logic        pinAOe,
  output logic        pinB,
  output logic        divIdle
);

  localparam int unsigned TAP_32K = 0;
  localparam int unsigned TAP_1HZ = DIV_W - 1;

  logic [DIV_W-1:0] divQ;
  logic             sqw;
  logic             aActive;

  always_ff @(posedge clk) begin
    if (!rstN)            divQ <= '0;
    else if (!strb.oscRun) divQ <= '0;
    else if (oscEdge)     divQ <= divQ + 1'b1;
  end

  assign divIdle = (divQ == '0);

  always_comb begin
    unique case (strb.rateSel)
      2'b11:   sqw = divQ[TAP_32K];
      2'b10:   sqw = divQ[TAP_8K];
      2'b01:   sqw = divQ[TAP_4K];
      default: sqw = divQ[TAP_1HZ];
    endcase
  end

  always_comb begin
    unique case ({strb.intSteer, strb.extClk})
      2'b00: begin pinAOe = 1'b1; aActive = strb.irq1 | strb.irq2; pinB = sqw; end
      2'b01: begin pinAOe = 1'b0; aActive = 1'b0; pinB = sqw; end
      2'b10: begin pinAOe = 1'b1; aActive = strb.irq1; pinB = ~strb.irq2; end
      default: begin pinAOe = 1'b0; aActive = 1'b0; pinB = ~(strb.irq1 | strb.irq2); end
    endcase
    pinA = ~aActive;
  end

endmodule

// File: rtl/rtc_ctrl_steer.sv
module rtc_ctrl_steer
  import rtc_ctrl_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regSel,
  input  logic       regWe,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       alarm1Match,
  input  logic       alarm2Match,
  input  logic       oscEdge,
  output logic       pinA,
  output logic       pinAOe,
  output logic       pinB
);

  ctl_strobe_t strb;
  logic [1:0]  flagQ;
  logic        divIdle;

  rtc_ctrl_regs #(.NUM_ALARMS(2)) regs_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWe(regWe),
    .regWdata(regWdata), .matchIn({alarm2Match, alarm1Match}),
    .regRdata(regRdata), .strb(strb), .flagQ(flagQ)
  );

  rtc_ctrl_dp #(.DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .oscEdge(oscEdge), .strb(strb),
    .pinA(pinA), .pinAOe(pinAOe), .pinB(pinB), .divIdle(divIdle)
  );

endmodule

// File: rtl/rtc_ctrl_steer_chk.sv
module rtc_ctrl_steer_chk
  import rtc_ctrl_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        alarm1Match,
  input logic        alarm2Match,
  input logic [1:0]  flagQ,
  input ctl_strobe_t strb,
  input logic        divIdle,
  input logic        pinA,
  input logic        pinAOe,
  input logic        pinB
);

  a_r3_a1_sets: assert property (@(posedge clk) disable iff (!rstN)
    alarm1Match |=> flagQ[0]);
  a_r3_a2_sets: assert property (@(posedge clk) disable iff (!rstN)
    alarm2Match |=> flagQ[1]);
  a_r4_no_spont_set: assert property (@(posedge clk) disable iff (!rstN)
    (!alarm1Match && !flagQ[0]) |=> !flagQ[0]);
  a_r11_div_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.oscRun |=> divIdle);
  a_r6_pina_released: assert property (@(posedge clk) disable iff (!rstN)
    strb.extClk |-> (!pinAOe && pinA));
  a_r5_pina_any: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.intSteer && !strb.extClk && (strb.irq1 || strb.irq2)) |-> !pinA);
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (strb.intSteer && !strb.irq1 && !strb.irq2) |-> (pinA && pinB));

endmodule

bind rtc_ctrl_steer rtc_ctrl_steer_chk chk_i (
  .clk(clk), .rstN(rstN), .alarm1Match(alarm1Match), .alarm2Match(alarm2Match),
  .flagQ(flagQ), .strb(strb), .divIdle(divIdle),
  .pinA(pinA), .pinAOe(pinAOe), .pinB(pinB)
);

// File: tb/rtc_ctrl_steer_tb_top.sv
`timescale 1ns/1ps
module rtc_ctrl_steer_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regSel = 1'b0;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       alarm1Match = 1'b0;
  logic       alarm2Match = 1'b0;
  logic       oscEdge = 1'b0;
  logic       pinA, pinAOe, pinB;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    int         kind;   // 0 rdata, 1 pinA, 2 pinAOe, 3 pinB
    logic [7:0] exp;
  } item_t;
  item_t sbQ[$];

  always #5 clk = ~clk;

  rtc_ctrl_steer dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata),
    .alarm1Match(alarm1Match), .alarm2Match(alarm2Match),
    .oscEdge(oscEdge), .pinA(pinA), .pinAOe(pinAOe), .pinB(pinB)
  );

  // monitor: compares queued expectations 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sbQ.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = sbQ.pop_front();
        case (it.kind)
          0: got = regRdata;
          1: got = {7'd0, pinA};
          2: got = {7'd0, pinAOe};
          default: got = {7'd0, pinB};
        endcase
        checks++;
        if (got !== it.exp) begin
          failures++;
          $display("FAIL %s actual=0x%02h expected=0x%02h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic expect_at(string tag, int kind, logic [7:0] exp);
    @(posedge clk);
    #1;
    sbQ.push_back('{tag, kind, exp});
    #2;
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWe = 1'b1; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(string tag, logic sel, logic [7:0] exp);
    @(negedge clk);
    regSel = sel;
    expect_at(tag, 0, exp);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    if (which == 1) alarm1Match = 1'b1; else alarm2Match = 1'b1;
    @(negedge clk);
    alarm1Match = 1'b0; alarm2Match = 1'b0;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    oscEdge = 1'b1;
    repeat (n) @(negedge clk);
    oscEdge = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd("R1 ctrl reset", 1'b0, 8'h18);
    rd("R1 stat reset", 1'b1, 8'h00);
    expect_at("R1 pinA", 1, 8'd1);
    expect_at("R1 pinAOe", 2, 8'd1);
    expect_at("R1 pinB", 3, 8'd0);

    // R2 write/readback, bit6 forced 0
    wr(1'b0, 8'hFF);
    rd("R2 ctrl readback bit6 zero", 1'b0, 8'hBF);
    wr(1'b0, 8'h18);
    rd("R2 ctrl readback", 1'b0, 8'h18);

    // R3 flags set with enables off; R9 no pin activity
    pulse(1);
    rd("R3 a1 flag set", 1'b1, 8'h01);
    expect_at("R9 disabled flag pinA high", 1, 8'd1);
    pulse(2);
    rd("R3 a2 flag set", 1'b1, 8'h03);

    // R4 clear semantics
    wr(1'b1, 8'h03);
    rd("R4 write ones no effect", 1'b1, 8'h03);
    wr(1'b1, 8'h02);
    rd("R4 clear a1 only", 1'b1, 8'h02);
    wr(1'b1, 8'h00);
    rd("R4 clear all", 1'b1, 8'h00);
    @(negedge clk);
    regSel = 1'b1; regWe = 1'b1; regWdata = 8'h00; alarm1Match = 1'b1;
    @(negedge clk);
    regWe = 1'b0; alarm1Match = 1'b0;
    rd("R4 set wins over clear", 1'b1, 8'h01);
    wr(1'b1, 8'h00);

    // R5 mode 00
    wr(1'b0, 8'h9B);
    wr(1'b0, 8'h1B);
    expect_at("R5 pinB sqw low", 3, 8'd0);
    ticks(1);
    expect_at("R5 pinB sqw high", 3, 8'd1);
    pulse(2);
    expect_at("R5 pinA low on enabled a2", 1, 8'd0);
    expect_at("R5 pinAOe driven", 2, 8'd1);

    // R6 mode 01
    wr(1'b1, 8'h04);
    pulse(1);
    expect_at("R6 pinAOe released", 2, 8'd0);
    expect_at("R6 pinA high", 1, 8'd1);
    expect_at("R6 pinB still sqw", 3, 8'd1);

    // R7 mode 10
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h1F);
    pulse(1);
    expect_at("R7 pinA low on a1", 1, 8'd0);
    expect_at("R7 pinB high no a2", 3, 8'd1);
    wr(1'b1, 8'h00);
    pulse(2);
    expect_at("R7 pinA high no a1", 1, 8'd1);
    expect_at("R7 pinB low on a2", 3, 8'd0);

    // R8 mode 11
    wr(1'b1, 8'h04);
    expect_at("R8 pinB high after clear", 3, 8'd1);
    pulse(1);
    expect_at("R8 pinB low on a1", 3, 8'd0);
    expect_at("R8 pinAOe released", 2, 8'd0);
    wr(1'b1, 8'h04);
    pulse(2);
    expect_at("R8 pinB low on a2", 3, 8'd0);

    // R9 steer mode with enables off
    wr(1'b0, 8'h1C);
    expect_at("R9 pinB high flag unenabled", 3, 8'd1);
    rd("R9 flag still set", 1'b1, 8'h06);
    wr(1'b1, 8'h00);

    // R10 rates
    wr(1'b0, 8'h90);
    wr(1'b0, 8'h10);
    ticks(3);
    expect_at("R10 8k low after 3", 3, 8'd0);
    ticks(1);
    expect_at("R10 8k high after 4", 3, 8'd1);
    wr(1'b0, 8'h88);
    wr(1'b0, 8'h08);
    ticks(7);
    expect_at("R10 4k low after 7", 3, 8'd0);
    ticks(1);
    expect_at("R10 4k high after 8", 3, 8'd1);
    wr(1'b0, 8'h80);
    wr(1'b0, 8'h00);
    ticks(32767);
    expect_at("R10 1Hz low after 32767", 3, 8'd0);
    ticks(1);
    expect_at("R10 1Hz high after 32768", 3, 8'd1);

    // R11 oscillator stop
    wr(1'b0, 8'h98);
    ticks(5);
    expect_at("R11 stopped sqw low", 3, 8'd0);
    wr(1'b0, 8'h18);
    expect_at("R11 restart from zero", 3, 8'd0);
    ticks(1);
    expect_at("R11 counts after restart", 3, 8'd1);

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule